// File: doc/BRIEF.md
# Mask to Vector Expansion Unit

This unit is one slice of a SIMD execution pipeline. It takes a predicate mask of up to 64 bits and turns it into a vector register value of up to 512 bits. Each mask bit becomes one whole element of the result. A set bit gives an element of all ones, and a clear bit gives an element of all zeros. Two opcode bytes and an element-width bit select one of four element sizes: 8, 16, 32 or 64 bits. A two-bit length code selects a 128-, 256- or 512-bit destination. Every result bit above the selected length is zero.

The decoder sends one request per cycle under `inValid`. The unit answers exactly one clock later. The answer is a registered 512-bit result, an output valid, a write enable and an undefined-instruction fault flag. A fault is raised when the reserved register-specifier field is not all ones, or when the length code is 3. A faulting request still produces a valid cycle, but the write enable stays low, so the retire logic can drop the update. Opcodes that belong to other units are ignored completely. The operation never changes any status flags.

Top module: `maskexp_unit`

## Requirements
- R1: Element width is decoded from `opcodeByte` and `wideBit`. 0x28 with `wideBit`=0 selects 8-bit elements, and with `wideBit`=1 selects 16-bit elements. 0x38 with `wideBit`=0 selects 32-bit elements, and with `wideBit`=1 selects 64-bit elements.
- R2: For a legal request, result element j (bits j*E to j*E+E-1 for element width E) is all ones when `maskIn[j]` is 1 and all zeros when it is 0.
- R3: `lenCode` 0, 1 and 2 select active lengths of 128, 256 and 512 bits. Every result bit at or above the active length is 0.
- R4: Mask bits at index (active length / element width) or higher have no effect on the result.
- R5: If `rsvdField` is not 4'b1111, the response has `outValid`=1, `outFault`=1 and `outWrEn`=0, and `resultOut` keeps its previous value.
- R6: `lenCode`=3 on a handled opcode behaves as a fault, exactly as in R5.
- R7: A request whose opcode is neither 0x28 nor 0x38 gives `outValid`=0 and `outFault`=0 on the next cycle, and `resultOut` does not change.
- R8: A handled request presented with `inValid` in one cycle drives its response on the outputs after the next rising edge. `outValid`, `outWrEn` and `outFault` are 0 in any cycle that follows no handled request, and back-to-back requests give back-to-back responses.
- R9: While `rstN` is low at a rising edge, `outValid`, `outWrEn`, `outFault` and `resultOut` are all cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Request strobe from decode |
| opcodeByte | input | 8 | Opcode byte of the request |
| wideBit | input | 1 | Element-width selector bit |
| lenCode | input | 2 | Vector-length code |
| rsvdField | input | 4 | Reserved register-specifier field, must be 1111 |
| maskIn | input | 64 | Source predicate mask |
| outValid | output | 1 | Response valid, one cycle after a handled request |
| outWrEn | output | 1 | Destination write enable |
| outFault | output | 1 | Undefined-instruction fault |
| resultOut | output | 512 | Expanded vector value |

## Verification
The bench exercises every pairing of the four element sizes and the three lengths. For each pairing it sets junk in the mask bits above the element count. A unit with a wrong element stride would smear bits across neighbouring elements. A unit with a wrong length clip would leak ones into the upper lanes or drop the top of the active range. Faults from the reserved field and from length code 3 come right after a legal write, so a unit that wrote on a fault would visibly corrupt the held result. Foreign opcodes, back-to-back requests, idle gaps and a reset in mid-stream catch stretched valids, missed latency and results that survive reset.

// File: rtl/maskexp_pkg.sv
package maskexp_pkg;

  parameter int unsigned MAX_VL = 512;

  localparam logic [7:0] OP_NARROW = 8'h28;
  localparam logic [7:0] OP_WIDE   = 8'h38;
  localparam logic [3:0] RSVD_OK   = 4'b1111;
  localparam logic [1:0] LEN_BAD   = 2'd3;

  typedef struct packed {
    logic       load;
    logic       fault;
    logic       write;
    logic [1:0] widthSel;
    logic [1:0] lenSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/maskexp_ctrl.sv
module maskexp_ctrl
  import maskexp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  opcodeByte,
  input  logic        wideBit,
  input  logic [1:0]  lenCode,
  input  logic [3:0]  rsvdField,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        outWrEn,
  output logic        outFault
);

  logic isNarrowOp;
  logic isWideOp;
  logic handled;
  logic badField;

  always_comb begin
    isNarrowOp      = (opcodeByte == OP_NARROW);
    isWideOp        = (opcodeByte == OP_WIDE);
    handled         = inValid && (isNarrowOp || isWideOp);
    badField        = (rsvdField != RSVD_OK) || (lenCode == LEN_BAD);
    strobe.load     = handled;
    strobe.fault    = handled && badField;
    strobe.write    = handled && !badField;
    strobe.widthSel = {isWideOp, wideBit};
    strobe.lenSel   = lenCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWrEn  <= 1'b0;
      outFault <= 1'b0;
    end else begin
      outValid <= strobe.load;
      outWrEn  <= strobe.write;
      outFault <= strobe.fault;
    end
  end

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    outFault |-> !outWrEn); // R5
  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outWrEn |-> outValid); // R8
  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opcodeByte == OP_NARROW || opcodeByte == OP_WIDE)) |=> outValid); // R8
  AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcodeByte != OP_NARROW && opcodeByte != OP_WIDE) |=> (!outValid && !outFault)); // R7
  AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opcodeByte == OP_NARROW || opcodeByte == OP_WIDE) && rsvdField != RSVD_OK)
    |=> (outFault && outValid)); // R5
  AST_LEN_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opcodeByte == OP_NARROW || opcodeByte == OP_WIDE) && lenCode == LEN_BAD)
    |=> outFault); // R6

endmodule

// File: rtl/maskexp_datapath.sv
module maskexp_datapath
  import maskexp_pkg::*;
#(
  parameter int unsigned VEC_W = MAX_VL
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [VEC_W/8-1:0] maskIn,
  output logic [VEC_W-1:0]   resultOut
);

  localparam int unsigned MASK_W   = VEC_W / 8;
  localparam int unsigned N_WIDTHS = 4;
  localparam int unsigned N_LENS   = 3;
  localparam int unsigned MIN_VL   = VEC_W / 4;

  logic [VEC_W-1:0] widthCand [N_WIDTHS];
  logic [VEC_W-1:0] lenClip   [N_LENS];
  logic [VEC_W-1:0] expanded;
  logic [VEC_W-1:0] clipMask;
  logic             writeQ;
  logic [1:0]       lenQ;

  for (genvar w = 0; w < N_WIDTHS; w++) begin : g_width
    localparam int unsigned ELEM_W = 8 << w;
    localparam int unsigned N_ELEM = VEC_W / ELEM_W;
    for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
      assign widthCand[w][e*ELEM_W +: ELEM_W] = {ELEM_W{maskIn[e]}};
    end
  end

  for (genvar l = 0; l < N_LENS; l++) begin : g_len
    localparam int unsigned ACT_VL = MIN_VL << l;
    assign lenClip[l] = {VEC_W{1'b1}} >> (VEC_W - ACT_VL);
  end

  always_comb begin
    expanded = widthCand[strobe.widthSel];
    clipMask = '0;
    if (strobe.lenSel != LEN_BAD) clipMask = lenClip[strobe.lenSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultOut <= '0;
      writeQ    <= 1'b0;
      lenQ      <= '0;
    end else begin
      writeQ <= strobe.write;
      lenQ   <= strobe.lenSel;
      if (strobe.write) resultOut <= expanded & clipMask;
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.write |=> $stable(resultOut)); // R5
  AST_UPPER_CLEAR_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (writeQ && lenQ == 2'd0) |-> (resultOut[VEC_W-1:MIN_VL] == '0)); // R3
  AST_UPPER_CLEAR_MID: assert property (@(posedge clk) disable iff (!rstN)
    (writeQ && lenQ == 2'd1) |-> (resultOut[VEC_W-1:2*MIN_VL] == '0)); // R3

  initial begin
    AST_MASK_WIDTH: assert (MASK_W * 8 == VEC_W); // R4
  end

endmodule

// File: rtl/maskexp_unit.sv
module maskexp_unit
  import maskexp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [7:0]   opcodeByte,
  input  logic         wideBit,
  input  logic [1:0]   lenCode,
  input  logic [3:0]   rsvdField,
  input  logic [63:0]  maskIn,
  output logic         outValid,
  output logic         outWrEn,
  output logic         outFault,
  output logic [511:0] resultOut
);

  ctrlStrobe_t strobe;

  maskexp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .opcodeByte (opcodeByte),
    .wideBit    (wideBit),
    .lenCode    (lenCode),
    .rsvdField  (rsvdField),
    .strobe     (strobe),
    .outValid   (outValid),
    .outWrEn    (outWrEn),
    .outFault   (outFault)
  );

  maskexp_datapath #(.VEC_W(512)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .maskIn    (maskIn),
    .resultOut (resultOut)
  );

endmodule

// File: tb/maskexp_unit_tb.sv
module maskexp_unit_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [7:0]   opcodeByte = 8'h00;
  logic         wideBit = 1'b0;
  logic [1:0]   lenCode = 2'd0;
  logic [3:0]   rsvdField = 4'hF;
  logic [63:0]  maskIn = '0;
  logic         outValid, outWrEn, outFault;
  logic [511:0] resultOut;

  int testCount = 0;
  int failCount = 0;
  string curTag = "R9";
  string tagQ   = "R9";

  logic         expValid = 1'b0, expWr = 1'b0, expFault = 1'b0;
  logic [511:0] expResult = '0;
  bit           checking = 1'b0;

  always #2 clk = ~clk;

  maskexp_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcodeByte(opcodeByte),
    .wideBit(wideBit), .lenCode(lenCode), .rsvdField(rsvdField), .maskIn(maskIn),
    .outValid(outValid), .outWrEn(outWrEn), .outFault(outFault), .resultOut(resultOut)
  );

  function automatic logic [511:0] refExpand(logic [7:0] op, logic w, logic [1:0] len,
                                             logic [63:0] m);
    logic [511:0] r;
    int elemBits;
    int vl;
    elemBits = (op == 8'h28) ? (w ? 16 : 8) : (w ? 64 : 32);
    vl = 128 << len;
    r = '0;
    for (int b = 0; b < 512; b++)
      if (b < vl) r[b] = m[b / elemBits];
    return r;
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    tagQ <= curTag;
    if (!rstN) begin
      expValid <= 1'b0; expWr <= 1'b0; expFault <= 1'b0; expResult <= '0;
    end else if (inValid && (opcodeByte == 8'h28 || opcodeByte == 8'h38)) begin
      expValid <= 1'b1;
      if (rsvdField != 4'hF || lenCode == 2'd3) begin
        expFault <= 1'b1; expWr <= 1'b0;
      end else begin
        expFault <= 1'b0; expWr <= 1'b1;
        expResult <= refExpand(opcodeByte, wideBit, lenCode, maskIn);
      end
    end else begin
      expValid <= 1'b0; expWr <= 1'b0; expFault <= 1'b0;
    end
  end

  task automatic checkBit(string what, string tag, logic act, logic exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (checking) begin
      checkBit("outValid", (tagQ == "R9") ? "R9" : "R8", outValid, expValid);
      checkBit("outWrEn", (expFault) ? "R5" : "R8", outWrEn, expWr);
      checkBit("outFault", (tagQ == "R6") ? "R6" : "R5", outFault, expFault);
      testCount++;
      if (resultOut !== expResult) begin
        failCount++;
        $display("FAIL %s resultOut: actual %h expected %h", tagQ, resultOut, expResult);
      end
    end
  end

  task automatic issue(string tag, logic [7:0] op, logic w, logic [1:0] len,
                       logic [3:0] rsvd, logic [63:0] m);
    @(negedge clk);
    curTag = tag; inValid = 1'b1; opcodeByte = op; wideBit = w;
    lenCode = len; rsvdField = rsvd; maskIn = m;
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    curTag = tag; inValid = 1'b0; maskIn = {2{$urandom()}};
    opcodeByte = 8'h28;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] ops [2];
    ops[0] = 8'h28; ops[1] = 8'h38;
    @(negedge clk);
    checking = 1'b1;
    repeat (3) idle("R9");
    rstN = 1'b1;
    // R1 R2 R3 R4: every width and length, junk above element count
    for (int o = 0; o < 2; o++)
      for (int w = 0; w < 2; w++)
        for (int l = 0; l < 3; l++) begin
          issue("R1", ops[o], w[0], l[1:0], 4'hF, 64'hA5A5_5A5A_F00F_3C3C);
          issue("R2", ops[o], w[0], l[1:0], 4'hF, 64'hFFFF_FFFF_FFFF_FFFF);
          issue("R4", ops[o], w[0], l[1:0], 4'hF, 64'hFFFF_FFFF_FFFF_FF00);
          issue("R3", ops[o], w[0], l[1:0], 4'hF, {$urandom(), $urandom()});
          idle("R8");
        end
    // R2 single-bit walk on 32-bit elements
    for (int j = 0; j < 16; j++) issue("R2", 8'h38, 1'b0, 2'd2, 4'hF, 64'd1 << j);
    // R5 fault after a write, result must hold
    issue("R5", 8'h28, 1'b0, 2'd2, 4'hF, 64'h0123_4567_89AB_CDEF);
    issue("R5", 8'h28, 1'b0, 2'd2, 4'hE, 64'hFFFF_FFFF_FFFF_FFFF);
    issue("R5", 8'h38, 1'b1, 2'd0, 4'h0, 64'h0);
    issue("R5", 8'h38, 1'b0, 2'd1, 4'h7, 64'h0);
    // R6 length code 3
    issue("R6", 8'h28, 1'b1, 2'd3, 4'hF, 64'hFFFF_FFFF_FFFF_FFFF);
    issue("R6", 8'h38, 1'b0, 2'd3, 4'hF, 64'h0);
    // R7 foreign opcodes
    issue("R7", 8'h29, 1'b0, 2'd2, 4'hF, 64'h0);
    issue("R7", 8'h00, 1'b1, 2'd0, 4'h0, 64'h0);
    issue("R7", 8'h39, 1'b0, 2'd3, 4'hF, 64'h0);
    idle("R8");
    // R8 random back-to-back traffic
    for (int k = 0; k < 200; k++) begin
      logic [3:0] rs;
      rs = ($urandom() % 8 == 0) ? 4'($urandom()) : 4'hF;
      if ($urandom() % 5 == 0) idle("R8");
      else issue("R8", ($urandom() % 6 == 0) ? 8'h30 : ops[$urandom() % 2],
                 1'($urandom()), 2'($urandom()), rs, {$urandom(), $urandom()});
    end
    // R9 reset in mid-stream
    issue("R9", 8'h38, 1'b1, 2'd2, 4'hF, 64'hFF);
    @(negedge clk);
    curTag = "R9"; rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1; inValid = 1'b0;
    idle("R9");
    issue("R2", 8'h28, 1'b0, 2'd1, 4'hF, 64'h8000_0000_0000_0001);
    idle("R8");
    idle("R8");
    @(negedge clk);
    finishRun();
  end

endmodule